// File: doc/BRIEF.md
# Converter Parallel Read Port with Byte Steering

This block sits between a microprocessor bus and the core of a 10-bit converter. It looks at three control inputs on each clock: a chip enable (active high), a chip select (active low), and a read/convert line. When enable and select are both asserted, the block has a bus access. The read/convert line, sampled when the access begins, decides the access type. A high line starts a read cycle, which presents the held result on the data lines. A low line starts a convert cycle, which sends a one-cycle start pulse to the conversion core.

The core delivers each finished result together with a one-cycle valid strobe, and the block keeps the most recent one. When a read begins, the block takes a snapshot of that held value. The data lines carry this snapshot until the read ends, so a result that arrives during the read never changes the data mid-cycle.

A format input picks how the 10-bit value is laid out on the lines. In wide mode the whole word goes out at once. In narrow mode an address bit selects one of two bytes, and every line that byte does not use is forced to zero. The block drives a data value and an output-enable flag. The tri-state pad buffers sit outside it.

The control is a four-state machine:
- `ST_IDLE` is the state with no access. An access with read high takes the transition *begin_read* to `ST_READ`. An access with read low takes the transition *begin_convert* to `ST_FIRE`.
- `ST_READ` stays while the access holds. When the access ends, it takes the transition *end_read* back to `ST_IDLE`.
- `ST_FIRE` lasts exactly one cycle and raises the start pulse. From there, *hold_convert* goes to `ST_HOLD` if the access still holds. Otherwise *abort_convert* goes to `ST_IDLE`.
- `ST_HOLD` waits for the access to end, then takes the transition *end_convert* to `ST_IDLE`.

Top module: `adc_bus_port`

## Requirements
- R1: An access exists only while `bus_en` is 1 and `bus_sel_n` is 0. With any other combination, `dout_oe` and `conv_start` stay 0.
- R2: Suppose the block is idle and a clock edge samples an access with `rd_nconv`=1. Then `dout_oe` is 1 from that edge on. It stays 1 while the access holds, and drops to 0 at the first edge that samples no access.
- R3: In a read with `wide_fmt`=1, `dout` equals the full 10-bit snapshot.
- R4: In a read with `wide_fmt`=0 and `byte_sel`=0, `dout[9:2]` carries snapshot bits 9..2 and `dout[1:0]` is 0.
- R5: In a read with `wide_fmt`=0 and `byte_sel`=1, `dout[9:8]` carries snapshot bits 1..0 and `dout[7:0]` is 0.
- R6: While `dout_oe` is 0, `dout` is all zeros.
- R7: Suppose the block is idle and a clock edge samples an access with `rd_nconv`=0. Then `conv_start` is 1 for exactly the one cycle after that edge. It does not pulse again until the access has ended and a new one has begun.
- R8: A read returns the value of the last `res_valid` strobe that came before the read began. A strobe during the read leaves `dout` unchanged until a later read.
- R9: A change of `rd_nconv` while an access holds has no effect. The access type fixed at its start is kept, so a read never produces a start pulse and a convert never enables the data lines.
- R10: After reset, `dout_oe` and `conv_start` are 0 and the held result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Chip enable, active high |
| bus_sel_n | input | 1 | Chip select, active low |
| rd_nconv | input | 1 | 1 = read cycle, 0 = convert request |
| wide_fmt | input | 1 | 1 = one 10-bit word, 0 = two bytes |
| byte_sel | input | 1 | Byte choice in narrow mode |
| res_valid | input | 1 | One-cycle strobe from the core: new result |
| res_data | input | 10 | Finished conversion result |
| conv_start | output | 1 | One-cycle start request to the core |
| dout | output | 10 | Steered data for the pad drivers |
| dout_oe | output | 1 | Enable for the tri-state pad drivers |

## Verification
The embedded properties check, on every cycle, the following:
- the data lines stay at zero while the output enable is low;
- the start pulse lasts a single cycle and only follows a sampled access;
- the enable and the start pulse are never high together;
- the unused low lines stay zero in the second byte;
- the data stays steady through a read while the format and address hold still.

The bench scenarios cover what those properties cannot see:
- that the value on the lines is the right one for each of the 1024 possible results in every layout;
- that a result arriving during a read only appears at the next read;
- that the full sweep of enable, select and read/convert combinations decodes correctly;
- that a flip of the read/convert line in mid-access is ignored.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_FIRE = 2'd2,
        ST_HOLD = 2'd3
    } bus_state_t;
endpackage

// File: rtl/adc_bus_fsm.sv
module adc_bus_fsm
    import adc_bus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic rd_line,
    output logic rd_active,
    output logic start_pulse,
    output logic snap_take
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (access) state_d = rd_line ? ST_READ : ST_FIRE;
            ST_READ: if (!access) state_d = ST_IDLE;
            ST_FIRE: state_d = access ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!access) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_active   = (state_q == ST_READ);
        start_pulse = (state_q == ST_FIRE);
        snap_take   = (state_q == ST_IDLE) && access && rd_line;
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R7
    AST_START_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> $past(access && !rd_line)); // R1
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             snap_take,
    output logic [RES_W-1:0] snap_q
);
    logic [RES_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            snap_q <= '0;
        end else begin
            if (res_valid) held_q <= res_data;
            if (snap_take) snap_q <= held_q;
        end
    end
endmodule

// File: rtl/adc_byte_steer.sv
module adc_byte_steer #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic             oe,
    input  logic             wide,
    input  logic             hi_byte,
    input  logic [RES_W-1:0] word,
    output logic [RES_W-1:0] bus
);
    localparam int LOW_W = RES_W - BYTE_W;

    logic [RES_W-1:0] first_byte, second_byte;

    generate
        if (LOW_W > 0) begin : g_split
            assign first_byte  = {word[RES_W-1:LOW_W], {LOW_W{1'b0}}};
            assign second_byte = {word[LOW_W-1:0], {(RES_W-LOW_W){1'b0}}};
        end else begin : g_flat
            assign first_byte  = word;
            assign second_byte = '0;
        end
    endgenerate

    always_comb begin
        if (!oe)       bus = '0;
        else if (wide) bus = word;
        else           bus = hi_byte ? second_byte : first_byte;
    end
endmodule

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_sel_n,
    input  logic             rd_nconv,
    input  logic             wide_fmt,
    input  logic             byte_sel,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    output logic             conv_start,
    output logic [RES_W-1:0] dout,
    output logic             dout_oe
);
    localparam int LOW_W = RES_W - BYTE_W;

    logic             access;
    logic             snap_take;
    logic [RES_W-1:0] snap;

    assign access = bus_en && !bus_sel_n;

    adc_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .access(access), .rd_line(rd_nconv),
        .rd_active(dout_oe), .start_pulse(conv_start), .snap_take(snap_take)
    );

    adc_result_hold #(.RES_W(RES_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .snap_take(snap_take), .snap_q(snap)
    );

    adc_byte_steer #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_steer (
        .oe(dout_oe), .wide(wide_fmt), .hi_byte(byte_sel), .word(snap), .bus(dout)
    );

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0); // R6
    AST_NO_OE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_oe && conv_start)); // R9
    AST_SECOND_BYTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !wide_fmt && byte_sel) |-> dout[RES_W-LOW_W-1:0] == '0); // R5
    AST_READ_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe) && $stable(wide_fmt) && $stable(byte_sel)) |-> $stable(dout)); // R8
    AST_OE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(access && rd_nconv)); // R2
endmodule

// File: tb/adc_bus_port_test.sv
module adc_bus_port_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_en = 0, bus_sel_n = 1, rd_nconv = 0, wide_fmt = 1, byte_sel = 0;
    logic       res_valid = 0;
    logic [9:0] res_data = '0;
    logic       conv_start, dout_oe;
    logic [9:0] dout;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_bus_port uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_sel_n(bus_sel_n),
        .rd_nconv(rd_nconv), .wide_fmt(wide_fmt), .byte_sel(byte_sel),
        .res_valid(res_valid), .res_data(res_data), .conv_start(conv_start),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(int v);
        res_data = 10'(v); res_valid = 1;
        tick();
        res_valid = 0;
    endtask

    task automatic idle_bus();
        bus_en = 0; bus_sel_n = 1;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R10 oe in reset", dout_oe, 0);
        chk("R10 start in reset", conv_start, 0);
        rst_n = 1;
        tick();
        chk("R10 oe after reset", dout_oe, 0);
        chk("R10 start after reset", conv_start, 0);
        // R10: held result is zero
        bus_en = 1; bus_sel_n = 0; rd_nconv = 1; wide_fmt = 1;
        tick();
        chk("R10 held result zero", dout, 0);
        idle_bus();

        // R1: sweep of enable/select/read-convert
        for (int c = 0; c < 8; c++) begin
            bus_en = c[0]; bus_sel_n = c[1]; rd_nconv = c[2];
            tick();
            if (c[0] && !c[1]) begin
                chk("R1 oe on access", dout_oe, c[2] ? 1 : 0);
                chk("R1 start on access", conv_start, c[2] ? 0 : 1);
            end else begin
                chk("R1 oe without access", dout_oe, 0);
                chk("R1 start without access", conv_start, 0);
            end
            idle_bus();
            chk("R6 dout zero when idle", dout, 0);
        end

        // R3 R4 R5 R2: exhaustive value sweep in every layout
        for (int v = 0; v < 1024; v++) begin
            load(v);
            bus_en = 1; bus_sel_n = 0; rd_nconv = 1;
            tick();
            chk("R2 oe during read", dout_oe, 1);
            wide_fmt = 1; #1;
            chk("R3 wide word", dout, v);
            wide_fmt = 0; byte_sel = 0; #1;
            chk("R4 first byte", dout, (v >> 2) << 2);
            byte_sel = 1; #1;
            chk("R5 second byte", dout, (v & 3) << 8);
            bus_sel_n = 1;
            tick();
            chk("R2 oe drops", dout_oe, 0);
            chk("R6 dout zero after read", dout, 0);
            wide_fmt = 1; byte_sel = 0; bus_en = 0;
        end

        // R8: new result during a read is held back
        load(10'h2A5);
        bus_en = 1; bus_sel_n = 0; rd_nconv = 1;
        tick();
        load(10'h15A);
        tick();
        chk("R8 snapshot kept", dout, 10'h2A5);
        idle_bus();
        bus_en = 1; bus_sel_n = 0;
        tick();
        chk("R8 next read shows new", dout, 10'h15A);
        idle_bus();

        // R7: single start pulse, no repeat while held
        bus_en = 1; bus_sel_n = 0; rd_nconv = 0;
        tick();
        chk("R7 start first cycle", conv_start, 1);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R7 no repeat pulse", conv_start, 0);
        end
        idle_bus();
        bus_en = 1; bus_sel_n = 0;
        tick();
        chk("R7 pulse after re-access", conv_start, 1);
        idle_bus();

        // R9: read/convert flip in mid-access
        bus_en = 1; bus_sel_n = 0; rd_nconv = 1;
        tick();
        rd_nconv = 0;
        tick(); tick();
        chk("R9 read keeps oe", dout_oe, 1);
        chk("R9 read no start", conv_start, 0);
        idle_bus();
        bus_en = 1; bus_sel_n = 0; rd_nconv = 0;
        tick();
        rd_nconv = 1;
        tick(); tick();
        chk("R9 convert no oe", dout_oe, 0);
        chk("R9 convert dout zero", dout, 0);
        idle_bus();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule